// File: doc/BRIEF.md
# SCSI Bus Wait Sequencer

This block carries out the waiting instructions of a small SCSI protocol engine. An instruction begins with a one-cycle start pulse and an operation code. The block then watches the bus and the CPU until the wait ends, and reports the result as a next-fetch address. That address is either the sequential instruction pointer supplied by the engine, or a 32-bit branch target supplied with the instruction.

Three operations exist. The disconnect wait finishes only after a Disconnect or Command Complete message has been noted. Busy and select must then both stay released for a full bus-free window. The window length is 400 ns divided by the clock period, rounded up to whole cycles. The reselect wait ends on a CPU abort, on being selected or on being reselected. Each of these picks its own fetch address, and selection and reselection also set the initiator/target role. The selection-phase operation drives the attention line, when requested, until the target answers by asserting busy.

Top module: `scsi_wait_seq`

## Requirements
- R1: While reset is high and on the cycle after it, done_o, atn_o and tgt_mode_o are 0, and next_addr_o is 0. Reset also forgets any message noted earlier, so a later disconnect wait needs a fresh message.
- R2: A start pulse with op_i = 0 begins a disconnect wait. Until msg_end_i has been high in some cycle, no amount of bus-free time ends that wait.
- R3: Once a message has been noted, the disconnect wait ends when bsy_n_i and sel_n_i have both been high for FREE_CYC consecutive sampled cycles. FREE_CYC = ceil(BUS_FREE_NS / CLK_NS). done_o rises on the cycle after the last of those cycles and next_addr_o = cur_ptr_i. The noted message is then used up.
- R4: If bsy_n_i or sel_n_i is low in a disconnect-wait cycle, the bus-free count starts over. Completion then needs FREE_CYC more consecutive free cycles.
- R5: A start pulse with op_i = 1 begins a reselect wait. A low rsl_n_i with sel_n_i high and cpu_sig_i low ends it with next_addr_o = cur_ptr_i and tgt_mode_o = 0 (initiator).
- R6: In a reselect wait, a low sel_n_i with cpu_sig_i low ends it with next_addr_o = jump_addr_i and tgt_mode_o = 1 (target). Selection wins over reselection when both arrive in the same cycle.
- R7: In a reselect wait, a high cpu_sig_i ends it with next_addr_o = jump_addr_i and leaves tgt_mode_o unchanged. This holds even when selection or reselection arrives in the same cycle.
- R8: A start pulse with op_i = 2 begins a selection phase. atn_o is high from the following cycle until the phase ends if with_atn_i was 1 at start, and stays 0 otherwise. The phase ends when bsy_n_i is low, giving done_o with next_addr_o = cur_ptr_i and atn_o = 0.
- R9: done_o is high for exactly one cycle per finished instruction. next_addr_o changes only in a cycle where done_o is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse beginning an instruction (ignored unless idle) |
| op_i | input | 2 | Operation: 0 disconnect wait, 1 reselect wait, 2 selection phase |
| with_atn_i | input | 1 | Drive attention during a selection phase |
| bsy_n_i | input | 1 | Bus busy, active low |
| sel_n_i | input | 1 | Bus select / selected indication, active low |
| rsl_n_i | input | 1 | Reselected indication, active low |
| msg_end_i | input | 1 | Disconnect or Command Complete message received |
| cpu_sig_i | input | 1 | CPU signal bit, aborts a reselect wait |
| jump_addr_i | input | ADDR_W | Branch target address |
| cur_ptr_i | input | ADDR_W | Sequential instruction pointer |
| next_addr_o | output | ADDR_W | Next fetch address |
| tgt_mode_o | output | 1 | 1 target, 0 initiator |
| done_o | output | 1 | Instruction finished, one-cycle pulse |
| atn_o | output | 1 | Attention drive |

## Verification
The bench builds the block with CLK_NS = 50 and the default 400 ns bus-free time, so the bus-free window is 8 cycles. At that length the exact completion cycle, and restarts close to the end of the window, can be checked in a few dozen cycles. ADDR_W stays at 32, so the branch target and the sequential pointer can be told apart in every reselect outcome.

// File: rtl/swq_pkg.sv
package swq_pkg;

    typedef enum logic [1:0] {
        OP_WAIT_DISC  = 2'd0,
        OP_WAIT_RESEL = 2'd1,
        OP_SELECT     = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WDISC  = 2'd1,
        ST_WRESEL = 2'd2,
        ST_WSEL   = 2'd3
    } state_e;

    typedef enum logic [1:0] {
        OUT_NONE       = 2'd0,
        OUT_ABORT      = 2'd1,
        OUT_SELECTED   = 2'd2,
        OUT_RESELECTED = 2'd3
    } outcome_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/swq_bus_free_timer.sv
module swq_bus_free_timer #(
    parameter int LIMIT = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic free_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          counting;

    assign counting = en_i && free_i;
    assign expire_o = counting && (cnt_q == LAST);

    always_comb begin
        cnt_d = '0;
        if (counting && !expire_o) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/swq_msg_tracker.sv
module swq_msg_tracker (
    input  logic clk,
    input  logic rst,
    input  logic msg_i,
    input  logic clr_i,
    output logic seen_o
);
    logic seen_d, seen_q;

    always_comb begin
        seen_d = seen_q;
        if (clr_i) begin
            seen_d = 1'b0;
        end
        if (msg_i) begin
            seen_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= seen_d;
        end
    end

    assign seen_o = seen_q;
endmodule

// File: rtl/swq_resel_decode.sv
module swq_resel_decode (
    input  logic               cpu_sig_i,
    input  logic               sel_act_i,
    input  logic               rsl_act_i,
    output swq_pkg::outcome_e  outcome_o
);
    always_comb begin
        if (cpu_sig_i) begin
            outcome_o = swq_pkg::OUT_ABORT;
        end else if (sel_act_i) begin
            outcome_o = swq_pkg::OUT_SELECTED;
        end else if (rsl_act_i) begin
            outcome_o = swq_pkg::OUT_RESELECTED;
        end else begin
            outcome_o = swq_pkg::OUT_NONE;
        end
    end
endmodule

// File: rtl/scsi_wait_seq.sv
module scsi_wait_seq #(
    parameter int ADDR_W      = 32,
    parameter int BUS_FREE_NS = 400,
    parameter int CLK_NS      = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic              with_atn_i,
    input  logic              bsy_n_i,
    input  logic              sel_n_i,
    input  logic              rsl_n_i,
    input  logic              msg_end_i,
    input  logic              cpu_sig_i,
    input  logic [ADDR_W-1:0] jump_addr_i,
    input  logic [ADDR_W-1:0] cur_ptr_i,
    output logic [ADDR_W-1:0] next_addr_o,
    output logic              tgt_mode_o,
    output logic              done_o,
    output logic              atn_o
);
    import swq_pkg::*;

    localparam int FREE_CYC = ceil_div(BUS_FREE_NS, CLK_NS);

    typedef struct packed {
        state_e            state;
        logic              done;
        logic [ADDR_W-1:0] next_addr;
        logic              tgt;
        logic              atn;
        logic              with_atn;
    } regs_t;

    regs_t    r_d, r_q;
    logic     msg_seen;
    logic     msg_clr;
    logic     timer_en;
    logic     expire;
    outcome_e outcome;

    swq_msg_tracker i_msg (
        .clk    (clk),
        .rst    (rst),
        .msg_i  (msg_end_i),
        .clr_i  (msg_clr),
        .seen_o (msg_seen)
    );

    swq_bus_free_timer #(.LIMIT(FREE_CYC)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .en_i     (timer_en),
        .free_i   (bsy_n_i && sel_n_i),
        .expire_o (expire)
    );

    swq_resel_decode i_decode (
        .cpu_sig_i (cpu_sig_i),
        .sel_act_i (!sel_n_i),
        .rsl_act_i (!rsl_n_i),
        .outcome_o (outcome)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        msg_clr  = 1'b0;
        timer_en = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    case (op_i)
                        OP_WAIT_DISC:  r_d.state = ST_WDISC;
                        OP_WAIT_RESEL: r_d.state = ST_WRESEL;
                        OP_SELECT: begin
                            r_d.state    = ST_WSEL;
                            r_d.with_atn = with_atn_i;
                        end
                        default:       r_d.state = ST_IDLE;
                    endcase
                end
            end
            ST_WDISC: begin
                timer_en = msg_seen;
                if (expire) begin
                    r_d.state     = ST_IDLE;
                    r_d.done      = 1'b1;
                    r_d.next_addr = cur_ptr_i;
                    msg_clr       = 1'b1;
                end
            end
            ST_WRESEL: begin
                unique case (outcome)
                    OUT_ABORT: begin
                        r_d.state     = ST_IDLE;
                        r_d.done      = 1'b1;
                        r_d.next_addr = jump_addr_i;
                    end
                    OUT_SELECTED: begin
                        r_d.state     = ST_IDLE;
                        r_d.done      = 1'b1;
                        r_d.next_addr = jump_addr_i;
                        r_d.tgt       = 1'b1;
                    end
                    OUT_RESELECTED: begin
                        r_d.state     = ST_IDLE;
                        r_d.done      = 1'b1;
                        r_d.next_addr = cur_ptr_i;
                        r_d.tgt       = 1'b0;
                    end
                    default: ;
                endcase
            end
            ST_WSEL: begin
                if (!bsy_n_i) begin
                    r_d.state     = ST_IDLE;
                    r_d.done      = 1'b1;
                    r_d.next_addr = cur_ptr_i;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        r_d.atn = (r_d.state == ST_WSEL) && r_d.with_atn;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_IDLE, done: 1'b0, next_addr: '0,
                     tgt: 1'b0, atn: 1'b0, with_atn: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign next_addr_o = r_q.next_addr;
    assign tgt_mode_o  = r_q.tgt;
    assign done_o      = r_q.done;
    assign atn_o       = r_q.atn;
endmodule

// File: rtl/swq_checker.sv
module swq_checker #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  swq_pkg::state_e   st,
    input  logic              msg_seen,
    input  logic              bsy_n_i,
    input  logic              sel_n_i,
    input  logic              rsl_n_i,
    input  logic              cpu_sig_i,
    input  logic [ADDR_W-1:0] jump_addr_i,
    input  logic [ADDR_W-1:0] cur_ptr_i,
    input  logic [ADDR_W-1:0] next_addr_o,
    input  logic              tgt_mode_o,
    input  logic              done_o,
    input  logic              atn_o
);
    import swq_pkg::*;

    assert_no_msg_no_done_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WDISC && !msg_seen) |=> !done_o);

    assert_bus_active_no_done_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WDISC && (!bsy_n_i || !sel_n_i)) |=> !done_o);

    assert_reselect_outcome_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WRESEL && !cpu_sig_i && !rsl_n_i && sel_n_i)
        |=> (done_o && next_addr_o == $past(cur_ptr_i) && !tgt_mode_o));

    assert_select_outcome_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WRESEL && !cpu_sig_i && !sel_n_i)
        |=> (done_o && next_addr_o == $past(jump_addr_i) && tgt_mode_o));

    assert_cpu_abort_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WRESEL && cpu_sig_i)
        |=> (done_o && next_addr_o == $past(jump_addr_i) && tgt_mode_o == $past(tgt_mode_o)));

    assert_atn_off_at_done_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !atn_o);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_addr_held_R9: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(next_addr_o));
endmodule

bind scsi_wait_seq swq_checker #(.ADDR_W(ADDR_W)) i_swq_checker (
    .clk         (clk),
    .rst         (rst),
    .st          (r_q.state),
    .msg_seen    (msg_seen),
    .bsy_n_i     (bsy_n_i),
    .sel_n_i     (sel_n_i),
    .rsl_n_i     (rsl_n_i),
    .cpu_sig_i   (cpu_sig_i),
    .jump_addr_i (jump_addr_i),
    .cur_ptr_i   (cur_ptr_i),
    .next_addr_o (next_addr_o),
    .tgt_mode_o  (tgt_mode_o),
    .done_o      (done_o),
    .atn_o       (atn_o)
);

// File: tb/test_scsi_wait_seq.sv
module test_scsi_wait_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int CLK_NS     = 50;
    localparam int FREE_NS    = 400;
    localparam int N          = (FREE_NS + CLK_NS - 1) / CLK_NS;
    localparam int WATCHDOG   = 20000;

    // vector bits: [3] cpu_sig, [2] selected, [1] reselected, [0] expected tgt
    localparam logic [3:0] VEC [8] = '{
        4'b0010, 4'b0101, 4'b1001, 4'b0010,
        4'b1100, 4'b0111, 4'b1011, 4'b0010
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [1:0]        op_i = 2'd0;
    logic              with_atn_i = 1'b0;
    logic              bsy_n_i = 1'b1;
    logic              sel_n_i = 1'b1;
    logic              rsl_n_i = 1'b1;
    logic              msg_end_i = 1'b0;
    logic              cpu_sig_i = 1'b0;
    logic [ADDR_W-1:0] jump_addr_i = '0;
    logic [ADDR_W-1:0] cur_ptr_i = '0;
    logic [ADDR_W-1:0] next_addr_o;
    logic              tgt_mode_o;
    logic              done_o;
    logic              atn_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    scsi_wait_seq #(.ADDR_W(ADDR_W), .BUS_FREE_NS(FREE_NS), .CLK_NS(CLK_NS)) i_scsi_wait_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .with_atn_i(with_atn_i),
        .bsy_n_i(bsy_n_i), .sel_n_i(sel_n_i), .rsl_n_i(rsl_n_i), .msg_end_i(msg_end_i),
        .cpu_sig_i(cpu_sig_i), .jump_addr_i(jump_addr_i), .cur_ptr_i(cur_ptr_i),
        .next_addr_o(next_addr_o), .tgt_mode_o(tgt_mode_o), .done_o(done_o), .atn_o(atn_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected <= %0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // counts negedges until done is seen; -1 if not within maxc
    task automatic wait_done(input int maxc, output int cnt);
        bit hit = 1'b0;
        cnt = -1;
        for (int c = 1; c <= maxc; c++) begin
            @(negedge clk);
            if (!hit && done_o) begin
                cnt = c;
                hit = 1'b1;
            end
            if (hit) break;
        end
    endtask

    task automatic begin_op(input logic [1:0] op, input logic [ADDR_W-1:0] cur);
        start_i   = 1'b1;
        op_i      = op;
        cur_ptr_i = cur;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic pulse_msg();
        msg_end_i = 1'b1;
        @(negedge clk);
        msg_end_i = 1'b0;
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        check("R1", "done in reset", {31'd0, done_o}, 0);
        check("R1", "atn in reset", {31'd0, atn_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "next_addr after reset", next_addr_o, 0);
        check("R1", "tgt after reset", {31'd0, tgt_mode_o}, 0);

        // R2: no message, bus free long
        begin_op(2'd0, 32'h0000_0100);
        wait_done(3 * N, c);
        check("R2", "done without message", c, -1);
        msg_end_i = 1'b1;
        @(negedge clk);
        msg_end_i = 1'b0;
        wait_done(N + 4, c);
        check("R3", "cycles after message", c, N);
        check("R3", "next_addr = cur_ptr", next_addr_o, 32'h0000_0100);

        // R3: message consumed, new wait needs new message
        begin_op(2'd0, 32'h0000_0180);
        wait_done(3 * N, c);
        check("R3", "message reused", c, -1);
        pulse_msg();
        wait_done(N + 4, c);
        check("R3", "drain second wait", c, N);

        // R3: message noted before start, exact latency
        pulse_msg();
        begin_op(2'd0, 32'h0000_0200);
        check("R3", "done too early", {31'd0, done_o}, 0);
        wait_done(N + 4, c);
        check("R3", "latency from start", c, N);
        check("R3", "next_addr second", next_addr_o, 32'h0000_0200);
        @(negedge clk);
        check("R9", "done one cycle", {31'd0, done_o}, 0);

        // R4: busy glitch near end restarts count
        pulse_msg();
        begin_op(2'd0, 32'h0000_0300);
        repeat (N - 3) @(negedge clk);
        check("R4", "done before glitch", {31'd0, done_o}, 0);
        bsy_n_i = 1'b0;
        @(negedge clk);
        bsy_n_i = 1'b1;
        wait_done(N + 4, c);
        check("R4", "restart after busy", c, N);

        // R4: select glitch
        pulse_msg();
        begin_op(2'd0, 32'h0000_0340);
        repeat (N - 2) @(negedge clk);
        sel_n_i = 1'b0;
        @(negedge clk);
        sel_n_i = 1'b1;
        wait_done(N + 4, c);
        check("R4", "restart after select", c, N);
        check("R4", "next_addr after select glitch", next_addr_o, 32'h0000_0340);

        // R5, R6, R7: reselect wait table
        for (int i = 0; i < 8; i++) begin
            logic [ADDR_W-1:0] exp_addr;
            jump_addr_i = 32'hA000_0000 + i;
            begin_op(2'd1, 32'h0000_1000 + 4 * i);
            check("R5", "no done while waiting", {31'd0, done_o}, 0);
            @(negedge clk);
            check("R5", "still waiting", {31'd0, done_o}, 0);
            cpu_sig_i = VEC[i][3];
            sel_n_i   = !VEC[i][2];
            rsl_n_i   = !VEC[i][1];
            exp_addr  = (VEC[i][3] || VEC[i][2]) ? (32'hA000_0000 + i) : (32'h0000_1000 + 4 * i);
            @(negedge clk);
            cpu_sig_i = 1'b0;
            sel_n_i   = 1'b1;
            rsl_n_i   = 1'b1;
            if (VEC[i][3]) begin
                check("R7", "abort done", {31'd0, done_o}, 1);
                check("R7", "abort addr", next_addr_o, exp_addr);
                check("R7", "abort tgt", {31'd0, tgt_mode_o}, {31'd0, VEC[i][0]});
            end else if (VEC[i][2]) begin
                check("R6", "select done", {31'd0, done_o}, 1);
                check("R6", "select addr", next_addr_o, exp_addr);
                check("R6", "select tgt", {31'd0, tgt_mode_o}, {31'd0, VEC[i][0]});
            end else begin
                check("R5", "reselect done", {31'd0, done_o}, 1);
                check("R5", "reselect addr", next_addr_o, exp_addr);
                check("R5", "reselect tgt", {31'd0, tgt_mode_o}, {31'd0, VEC[i][0]});
            end
            jump_addr_i = 32'hDEAD_0000;
            cur_ptr_i   = 32'hBEEF_0000;
            @(negedge clk);
            check("R9", "done pulse width", {31'd0, done_o}, 0);
            @(negedge clk);
            check("R9", "addr held", next_addr_o, exp_addr);
        end

        // R8: selection phase with attention
        with_atn_i = 1'b1;
        begin_op(2'd2, 32'h0000_2000);
        with_atn_i = 1'b0;
        check("R8", "atn on", {31'd0, atn_o}, 1);
        repeat (3) @(negedge clk);
        check("R8", "atn held", {31'd0, atn_o}, 1);
        check("R8", "no done before busy", {31'd0, done_o}, 0);
        bsy_n_i = 1'b0;
        @(negedge clk);
        bsy_n_i = 1'b1;
        check("R8", "done on busy", {31'd0, done_o}, 1);
        check("R8", "atn off", {31'd0, atn_o}, 0);
        check("R8", "select next addr", next_addr_o, 32'h0000_2000);

        // R8: selection phase without attention
        begin_op(2'd2, 32'h0000_2100);
        repeat (2) @(negedge clk);
        check("R8", "atn stays off", {31'd0, atn_o}, 0);
        bsy_n_i = 1'b0;
        @(negedge clk);
        bsy_n_i = 1'b1;
        check("R8", "done without atn", {31'd0, done_o}, 1);

        // R1: reset forgets a noted message
        pulse_msg();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "next_addr cleared", next_addr_o, 0);
        begin_op(2'd0, 32'h0000_3000);
        wait_done(3 * N, c);
        check("R1", "message forgotten", c, -1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "done after reset", {31'd0, done_o}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule